// File: doc/BRIEF.md
# Boosted Haar Stage Evaluator

This block scores one stage of a boosted cascade for a detection window held as an integral image. A sequencer outside the block presents one weak classifier per clock. Each classifier brings up to `NUM_RECT` rectangles, given as four corner samples each, together with a small signed weight per rectangle, a feature threshold, two candidate votes, and the stage threshold.

Inside the block, each rectangle's area sum comes from its corners and is scaled by its weight. The weighted sums add up to a feature value. A signed comparison of that value with the feature threshold picks one of the two votes. The picked votes of a stage add up in an accumulator. When the stage's last classifier has been accounted for, the block gives a one-cycle completion pulse with a pass/fail verdict and the stage total.

The block does not fetch integral image samples, store classifier parameters or decide which stage runs next. A controller above it starts a stage, streams the classifiers at up to one per cycle and reads the verdict.

Top module: `haar_stage_eval`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `done_o` and `pass_o` are 0 and `stage_sum_o` is 0.
- R2: Rectangle r takes its corners from `corners_i[(4*r+k)*SAMPLE_W +: SAMPLE_W]`, with k=0 top-left (A), k=1 top-right (B), k=2 bottom-left (C) and k=3 bottom-right (D), all unsigned. Its area sum is D − B − C + A, and this sum may be negative.
- R3: The weight of rectangle r is `weights_i[r*WEIGHT_W +: WEIGHT_W]`, in two's complement. The feature value is the sum over all rectangles of area sum × weight. A rectangle with weight 0 adds nothing, whatever its corners are.
- R4: The feature value and `feat_thr_i` are compared as signed numbers. When the feature value is strictly below the threshold, `vote_left_i` is picked. Otherwise `vote_right_i` is picked.
- R5: The stage total is the signed sum of the votes picked for every classifier presented with `feat_valid_i` high, from the stage's first classifier up to and including the one marked `feat_last_i`. A new stage begins at 0 after a `start_i` cycle and after each last classifier. A classifier presented in the same cycle as `start_i` counts toward the new stage.
- R6: `pass_o` is 1 exactly when the stage total is greater than or equal to `stage_thr_i` as sampled with the last classifier (signed). `pass_o` is never 1 without `done_o`.
- R7: `done_o` is high for the single cycle that starts two clock edges after the last classifier is presented. In that cycle `stage_sum_o` carries the stage total, and it holds that value until the next completion.
- R8: Cycles with `feat_valid_i` low add nothing and cannot complete a stage, even when `feat_last_i` is high.
- R9: A `start_i` presented in the cycle after a last classifier discards that classifier. No completion follows it, and `stage_sum_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Clears the stage accumulator and drops any classifier still in flight |
| feat_valid_i | input | 1 | A classifier is presented this cycle |
| feat_last_i | input | 1 | The presented classifier is the last of its stage |
| corners_i | input | NUM_RECT*4*SAMPLE_W | Corner samples of every rectangle (layout in R2) |
| weights_i | input | NUM_RECT*WEIGHT_W | Signed rectangle weights (layout in R3) |
| feat_thr_i | input | FEAT_W | Signed feature threshold |
| vote_left_i | input | VOTE_W | Signed vote picked when the feature is below its threshold |
| vote_right_i | input | VOTE_W | Signed vote picked otherwise |
| stage_thr_i | input | STAGE_W | Signed stage threshold, sampled with the last classifier |
| done_o | output | 1 | One-cycle stage completion pulse |
| pass_o | output | 1 | Stage verdict, valid with `done_o` |
| stage_sum_o | output | STAGE_W | Stage total, updated at completion |

## Verification
A wrong corner sign, a mis-extended weight or a wrong threshold direction changes the picked vote. That error shows up in `stage_sum_o` in the very completion cycle of the stage being scored, two edges after its last classifier. A stuck or stale accumulator shows up in the next stage's total, because each stage must start from zero. A pipeline valid or last flag that is lost or repeated shows up as a `done_o` that is missing or misplaced in that same two-edge window. Sweeping every weight value against area sums that sit at, and one step past, their thresholds makes each of these errors move either the total or the verdict.

// File: rtl/haar_eval_pkg.sv
// Shared constants and width helpers for the stage evaluator.
// Assumes: callers pass positive widths and counts.
package haar_eval_pkg;

    localparam int CORNER_TL = 0;
    localparam int CORNER_TR = 1;
    localparam int CORNER_BL = 2;
    localparam int CORNER_BR = 3;
    localparam int CORNERS   = 4;

    // Width of one weighted rectangle term: area sum (two guard bits) times weight.
    function automatic int term_width(int sample_w, int weight_w);
        return sample_w + 2 + weight_w;
    endfunction

    // Width of a feature value: sum of nrect terms plus one guard bit.
    function automatic int feat_width(int sample_w, int weight_w, int nrect);
        return term_width(sample_w, weight_w) + $clog2(nrect) + 1;
    endfunction

    // Width of a stage total: max_feats votes plus one guard bit.
    function automatic int stage_width(int vote_w, int max_feats);
        return vote_w + $clog2(max_feats) + 1;
    endfunction

endpackage

// File: rtl/haar_rect_term.sv
// One weighted rectangle term: area sum from four integral-image corners,
// scaled by a signed weight. Purely combinational.
// Assumes: corners are unsigned samples; weight is two's complement.
module haar_rect_term
    import haar_eval_pkg::*;
#(
    parameter int SAMPLE_W = 17,
    parameter int WEIGHT_W = 3,
    localparam int TERM_W  = term_width(SAMPLE_W, WEIGHT_W),
    localparam int AREA_W  = SAMPLE_W + 2
) (
    input  logic [SAMPLE_W-1:0]        tl_i,
    input  logic [SAMPLE_W-1:0]        tr_i,
    input  logic [SAMPLE_W-1:0]        bl_i,
    input  logic [SAMPLE_W-1:0]        br_i,
    input  logic signed [WEIGHT_W-1:0] wt_i,
    output logic signed [TERM_W-1:0]   term_o
);

    logic signed [AREA_W-1:0] area;
    logic signed [TERM_W-1:0] area_x;
    logic signed [TERM_W-1:0] wt_x;

    // Area sum D - B - C + A in signed arithmetic with guard bits.
    always_comb begin
        area = $signed({2'b00, br_i}) - $signed({2'b00, tr_i})
             - $signed({2'b00, bl_i}) + $signed({2'b00, tl_i});
    end

    // Sign-extend both factors to the term width and multiply.
    always_comb begin
        area_x = {{WEIGHT_W{area[AREA_W-1]}}, area};
        wt_x   = {{(TERM_W-WEIGHT_W){wt_i[WEIGHT_W-1]}}, wt_i};
        term_o = area_x * wt_x;
    end

endmodule

// File: rtl/haar_feature_unit.sv
// Feature value stage: builds every rectangle term, adds them, and registers
// the feature value with the classifier's threshold, votes and control flags.
// Assumes: one classifier per cycle; parameters held only while valid is high.
module haar_feature_unit
    import haar_eval_pkg::*;
#(
    parameter int SAMPLE_W = 17,
    parameter int WEIGHT_W = 3,
    parameter int NUM_RECT = 3,
    parameter int VOTE_W   = 12,
    parameter int STAGE_W  = 19,
    localparam int TERM_W  = term_width(SAMPLE_W, WEIGHT_W),
    localparam int FEAT_W  = feat_width(SAMPLE_W, WEIGHT_W, NUM_RECT),
    localparam int EXT_W   = FEAT_W - TERM_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              feat_valid_i,
    input  logic                              feat_last_i,
    input  logic [NUM_RECT*CORNERS*SAMPLE_W-1:0] corners_i,
    input  logic [NUM_RECT*WEIGHT_W-1:0]      weights_i,
    input  logic signed [FEAT_W-1:0]          feat_thr_i,
    input  logic signed [VOTE_W-1:0]          vote_left_i,
    input  logic signed [VOTE_W-1:0]          vote_right_i,
    input  logic signed [STAGE_W-1:0]         stage_thr_i,
    output logic                              valid_q,
    output logic                              last_q,
    output logic signed [FEAT_W-1:0]          fval_q,
    output logic signed [FEAT_W-1:0]          fthr_q,
    output logic signed [VOTE_W-1:0]          vleft_q,
    output logic signed [VOTE_W-1:0]          vright_q,
    output logic signed [STAGE_W-1:0]         sthr_q
);

    logic signed [TERM_W-1:0] term_w [NUM_RECT];
    logic signed [FEAT_W-1:0] fsum;

    genvar gr;
    generate
        for (gr = 0; gr < NUM_RECT; gr++) begin : g_rect
            localparam int BASE = gr * CORNERS * SAMPLE_W;
            haar_rect_term #(
                .SAMPLE_W (SAMPLE_W),
                .WEIGHT_W (WEIGHT_W)
            ) u_term (
                .tl_i   (corners_i[BASE + CORNER_TL*SAMPLE_W +: SAMPLE_W]),
                .tr_i   (corners_i[BASE + CORNER_TR*SAMPLE_W +: SAMPLE_W]),
                .bl_i   (corners_i[BASE + CORNER_BL*SAMPLE_W +: SAMPLE_W]),
                .br_i   (corners_i[BASE + CORNER_BR*SAMPLE_W +: SAMPLE_W]),
                .wt_i   ($signed(weights_i[gr*WEIGHT_W +: WEIGHT_W])),
                .term_o (term_w[gr])
            );
        end
    endgenerate

    // Adder tree over all weighted rectangle terms (sign-extended).
    always_comb begin
        fsum = '0;
        for (int r = 0; r < NUM_RECT; r++) begin
            fsum = fsum + {{EXT_W{term_w[r][TERM_W-1]}}, term_w[r]};
        end
    end

    // Control flags of the pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            last_q  <= 1'b0;
        end else begin
            valid_q <= feat_valid_i;
            last_q  <= feat_valid_i & feat_last_i;
        end
    end

    // Data of the pipeline register, loaded only for a presented classifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fval_q   <= '0;
            fthr_q   <= '0;
            vleft_q  <= '0;
            vright_q <= '0;
            sthr_q   <= '0;
        end else if (feat_valid_i) begin
            fval_q   <= fsum;
            fthr_q   <= feat_thr_i;
            vleft_q  <= vote_left_i;
            vright_q <= vote_right_i;
            sthr_q   <= stage_thr_i;
        end
    end

endmodule

// File: rtl/haar_vote_accum.sv
// Vote stage: compares the registered feature value with its threshold,
// picks a vote, accumulates the stage total and issues the verdict.
// Assumes: no more than MAX_FEATS classifiers per stage (total cannot wrap).
module haar_vote_accum #(
    parameter int FEAT_W  = 25,
    parameter int VOTE_W  = 12,
    parameter int STAGE_W = 19,
    localparam int EXT_W  = STAGE_W - VOTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      valid_i,
    input  logic                      last_i,
    input  logic signed [FEAT_W-1:0]  fval_i,
    input  logic signed [FEAT_W-1:0]  fthr_i,
    input  logic signed [VOTE_W-1:0]  vleft_i,
    input  logic signed [VOTE_W-1:0]  vright_i,
    input  logic signed [STAGE_W-1:0] sthr_i,
    output logic                      done_o,
    output logic                      pass_o,
    output logic signed [STAGE_W-1:0] sum_o
);

    logic signed [VOTE_W-1:0]  vote;
    logic signed [STAGE_W-1:0] acc;
    logic signed [STAGE_W-1:0] total;

    // Strict signed comparison picks the left vote, otherwise the right one.
    always_comb begin
        vote  = (fval_i < fthr_i) ? vleft_i : vright_i;
        total = acc + {{EXT_W{vote[VOTE_W-1]}}, vote};
    end

    // Accumulator: cleared by start or stage end, grows with each vote.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (start_i) begin
            acc <= '0;
        end else if (valid_i) begin
            acc <= last_i ? '0 : total;
        end
    end

    // Completion pulse, verdict and held total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            pass_o <= 1'b0;
            sum_o  <= '0;
        end else begin
            done_o <= 1'b0;
            pass_o <= 1'b0;
            if (!start_i && valid_i && last_i) begin
                done_o <= 1'b1;
                pass_o <= (total >= sthr_i);
                sum_o  <= total;
            end
        end
    end

endmodule

// File: rtl/haar_stage_eval.sv
// Top of the stage evaluator: feature unit followed by vote accumulator.
// Latency from last classifier to completion pulse is two clock edges.
// Assumes: an external sequencer streams classifiers and owns the cascade.
module haar_stage_eval
    import haar_eval_pkg::*;
#(
    parameter int SAMPLE_W  = 17,
    parameter int WEIGHT_W  = 3,
    parameter int NUM_RECT  = 3,
    parameter int VOTE_W    = 12,
    parameter int MAX_FEATS = 64,
    localparam int FEAT_W   = feat_width(SAMPLE_W, WEIGHT_W, NUM_RECT),
    localparam int STAGE_W  = stage_width(VOTE_W, MAX_FEATS)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic                                  feat_valid_i,
    input  logic                                  feat_last_i,
    input  logic [NUM_RECT*CORNERS*SAMPLE_W-1:0]  corners_i,
    input  logic [NUM_RECT*WEIGHT_W-1:0]          weights_i,
    input  logic signed [FEAT_W-1:0]              feat_thr_i,
    input  logic signed [VOTE_W-1:0]              vote_left_i,
    input  logic signed [VOTE_W-1:0]              vote_right_i,
    input  logic signed [STAGE_W-1:0]             stage_thr_i,
    output logic                                  done_o,
    output logic                                  pass_o,
    output logic signed [STAGE_W-1:0]             stage_sum_o
);

    logic                      p_valid;
    logic                      p_last;
    logic signed [FEAT_W-1:0]  p_fval;
    logic signed [FEAT_W-1:0]  p_fthr;
    logic signed [VOTE_W-1:0]  p_vleft;
    logic signed [VOTE_W-1:0]  p_vright;
    logic signed [STAGE_W-1:0] p_sthr;

    haar_feature_unit #(
        .SAMPLE_W (SAMPLE_W),
        .WEIGHT_W (WEIGHT_W),
        .NUM_RECT (NUM_RECT),
        .VOTE_W   (VOTE_W),
        .STAGE_W  (STAGE_W)
    ) u_feat (
        .clk          (clk),
        .rst_n        (rst_n),
        .feat_valid_i (feat_valid_i),
        .feat_last_i  (feat_last_i),
        .corners_i    (corners_i),
        .weights_i    (weights_i),
        .feat_thr_i   (feat_thr_i),
        .vote_left_i  (vote_left_i),
        .vote_right_i (vote_right_i),
        .stage_thr_i  (stage_thr_i),
        .valid_q      (p_valid),
        .last_q       (p_last),
        .fval_q       (p_fval),
        .fthr_q       (p_fthr),
        .vleft_q      (p_vleft),
        .vright_q     (p_vright),
        .sthr_q       (p_sthr)
    );

    haar_vote_accum #(
        .FEAT_W  (FEAT_W),
        .VOTE_W  (VOTE_W),
        .STAGE_W (STAGE_W)
    ) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .valid_i  (p_valid),
        .last_i   (p_last),
        .fval_i   (p_fval),
        .fthr_i   (p_fthr),
        .vleft_i  (p_vleft),
        .vright_i (p_vright),
        .sthr_i   (p_sthr),
        .done_o   (done_o),
        .pass_o   (pass_o),
        .sum_o    (stage_sum_o)
    );

endmodule

// File: rtl/haar_stage_eval_chk.sv
// Port-level protocol checks for the stage evaluator, bound to its top.
// Assumes: synchronous active-low reset held for at least two edges.
module haar_stage_eval_chk #(
    parameter int STAGE_W = 19
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic                      feat_valid_i,
    input logic                      feat_last_i,
    input logic                      done_o,
    input logic                      pass_o,
    input logic signed [STAGE_W-1:0] stage_sum_o
);

    logic in_rst_q;
    logic armed_q;

    // Track that reset was seen, so history-based checks start from known values.
    always_ff @(posedge clk) begin
        in_rst_q <= !rst_n;
        armed_q  <= armed_q | in_rst_q;
    end

    // R1: outputs are clear in the cycle after any reset edge.
    always_ff @(posedge clk) begin
        if (in_rst_q) begin
            p_reset_clear_r1: assert (!done_o && !pass_o && stage_sum_o == '0)
                else $error("outputs not clear after reset");
        end
    end

    // R6: a verdict only appears with a completion pulse.
    p_pass_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> done_o);

    // R7: completion only two edges after a presented last classifier.
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(feat_valid_i && feat_last_i, 2));

    // R7: the total is held between completions.
    p_sum_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !done_o) |-> $stable(stage_sum_o));

    // R9: no completion in the cycle after a start.
    p_start_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_i) |-> !done_o);

endmodule

bind haar_stage_eval haar_stage_eval_chk #(.STAGE_W(STAGE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .feat_valid_i (feat_valid_i),
    .feat_last_i  (feat_last_i),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .stage_sum_o  (stage_sum_o)
);

// File: tb/haar_stage_eval_test.sv
// Self-checking bench: weight/area sweeps around thresholds, random stages
// with gaps, and start/abort corner cases. Expected totals are computed here.
module haar_stage_eval_test;

    localparam int SW  = 17;
    localparam int WW  = 3;
    localparam int NR  = 3;
    localparam int VW  = 12;
    localparam int MF  = 64;
    localparam int FW  = SW + 2 + WW + $clog2(NR) + 1;
    localparam int STW = VW + $clog2(MF) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic feat_valid_i = 1'b0;
    logic feat_last_i = 1'b0;
    logic [NR*4*SW-1:0] corners_i = '0;
    logic [NR*WW-1:0] weights_i = '0;
    logic signed [FW-1:0] feat_thr_i = '0;
    logic signed [VW-1:0] vote_left_i = '0;
    logic signed [VW-1:0] vote_right_i = '0;
    logic signed [STW-1:0] stage_thr_i = '0;
    logic done_o;
    logic pass_o;
    logic signed [STW-1:0] stage_sum_o;

    always #10 clk = ~clk;

    haar_stage_eval uut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .feat_valid_i (feat_valid_i), .feat_last_i (feat_last_i),
        .corners_i (corners_i), .weights_i (weights_i),
        .feat_thr_i (feat_thr_i), .vote_left_i (vote_left_i),
        .vote_right_i (vote_right_i), .stage_thr_i (stage_thr_i),
        .done_o (done_o), .pass_o (pass_o), .stage_sum_o (stage_sum_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int c [NR][4];
    int w [NR];
    longint fthr_b, sthr_b, vlo_b, vhi_b;
    longint exp_acc = 0, exp_total = 0, last_sum = 0;
    logic [31:0] seed = 32'h1234_abcd;

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic longint feat_val();
        longint s = 0;
        for (int r = 0; r < NR; r++)
            s += longint'(c[r][3] - c[r][1] - c[r][2] + c[r][0]) * w[r];
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic feed(input bit last, input bit st);
        longint v;
        for (int r = 0; r < NR; r++) begin
            for (int k = 0; k < 4; k++) corners_i[(r*4+k)*SW +: SW] = SW'(c[r][k]);
            weights_i[r*WW +: WW] = WW'(w[r]);
        end
        feat_thr_i = FW'(fthr_b);
        vote_left_i = VW'(vlo_b);
        vote_right_i = VW'(vhi_b);
        stage_thr_i = STW'(sthr_b);
        feat_valid_i = 1'b1;
        feat_last_i = last;
        start_i = st;
        v = (feat_val() < fthr_b) ? vlo_b : vhi_b;
        if (st) exp_acc = 0;
        exp_acc += v;
        if (last) begin
            exp_total = exp_acc;
            exp_acc = 0;
        end
        @(posedge clk); @(negedge clk);
        feat_valid_i = 1'b0;
        feat_last_i = 1'b0;
        start_i = 1'b0;
    endtask

    task automatic expect_done(input string tag);
        @(posedge clk); @(negedge clk);
        chk(done_o == 1'b1, {tag, " R7 done pulse"}, done_o, 1);
        chk(stage_sum_o == exp_total, {tag, " R5 total"}, stage_sum_o, exp_total);
        chk(pass_o == (exp_total >= sthr_b), {tag, " R6 verdict"}, pass_o, (exp_total >= sthr_b));
        last_sum = exp_total;
        @(posedge clk); @(negedge clk);
        chk(done_o == 1'b0, {tag, " R7 single cycle"}, done_o, 0);
        chk(stage_sum_o == last_sum, {tag, " R7 total held"}, stage_sum_o, last_sum);
    endtask

    task automatic rand_corners();
        for (int r = 0; r < NR; r++)
            for (int k = 0; k < 4; k++) c[r][k] = int'(rnd() % 131072);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int pat [4][4] = '{'{0, 0, 0, 131071}, '{5, 100, 200, 1000},
                           '{0, 70000, 90000, 0}, '{131071, 1, 2, 3}};
        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(done_o == 0, "R1 done in reset", done_o, 0);
        chk(pass_o == 0, "R1 pass in reset", pass_o, 0);
        chk(stage_sum_o == 0, "R1 sum in reset", stage_sum_o, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(done_o == 0 && stage_sum_o == 0, "R1 after reset", done_o, 0);

        // R2 R3 R4: every weight against fixed area patterns, at and just past threshold
        for (int wi = -4; wi < 4; wi++) begin
            for (int p = 0; p < 4; p++) begin
                for (int side = 0; side < 2; side++) begin
                    int act;
                    longint fv;
                    act = (wi + 4 + p) % NR;
                    rand_corners();
                    for (int r = 0; r < NR; r++) w[r] = 0;
                    for (int k = 0; k < 4; k++) c[act][k] = pat[p][k];
                    w[act] = wi;
                    fv = feat_val();
                    fthr_b = fv + side;      // side 0: equal -> right; side 1: below -> left
                    vlo_b = 100;
                    vhi_b = -200;
                    sthr_b = (side == 0) ? -200 : 101;
                    feed(1'b1, 1'b1);
                    expect_done("R2 R3 R4 sweep");
                end
            end
        end

        // R5 R6 R8: random multi-classifier stages with gaps and boundary thresholds
        for (int s = 0; s < 24; s++) begin
            int n;
            n = 1 + int'(rnd() % 8);
            for (int f = 0; f < n; f++) begin
                bit st;
                bit last;
                longint base, v;
                st = (f == 0) && (s % 2 == 0);
                last = (f == n - 1);
                rand_corners();
                for (int r = 0; r < NR; r++) w[r] = int'(rnd() % 8) - 4;
                fthr_b = feat_val() + longint'(rnd() % 3) - 1;
                vlo_b = longint'(rnd() % 4096) - 2048;
                vhi_b = longint'(rnd() % 4096) - 2048;
                base = st ? 0 : exp_acc;
                v = (feat_val() < fthr_b) ? vlo_b : vhi_b;
                sthr_b = base + v + longint'(rnd() % 3) - 1;
                feed(last, st);
                if (!last && (rnd() % 4 == 0)) begin
                    feat_last_i = 1'b1;  // R8: last without valid is ignored
                    @(posedge clk); @(negedge clk);
                    feat_last_i = 1'b0;
                    chk(done_o == 0, "R8 gap no completion", done_o, 0);
                end
            end
            expect_done("R5 R6 random stage");
        end

        // R8: a lone last flag without valid never completes
        feat_last_i = 1'b1;
        @(posedge clk); @(negedge clk);
        feat_last_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(done_o == 0, "R8 last without valid", done_o, 0);
        chk(stage_sum_o == last_sum, "R8 total untouched", stage_sum_o, last_sum);

        // R9: start right after a last classifier discards it
        for (int r = 0; r < NR; r++) w[r] = 1;
        rand_corners();
        fthr_b = 0; vlo_b = -5; vhi_b = 777; sthr_b = 0;
        feed(1'b1, 1'b0);
        vlo_b = 11; vhi_b = 22;
        feed(1'b0, 1'b1);
        chk(done_o == 0, "R9 aborted completion", done_o, 0);
        chk(stage_sum_o == last_sum, "R9 total kept", stage_sum_o, last_sum);
        vlo_b = 300; vhi_b = 400; sthr_b = 1000;
        feed(1'b1, 1'b0);
        expect_done("R9 stage after abort");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule